// File: doc/BRIEF.md
# Configuration Register Bank with Per-Register Default Override

This block holds the byte-wide configuration of a supervisory controller. A serial bus slave outside it turns bus traffic into three strobes: a transaction start, a received write byte and a read request. The first byte after a start loads a 7-bit address pointer. The next byte is written to the register that pointer selects. Reads always use the current pointer, so the pointer can be loaded once and then read again and again. Every configuration register has a constant power-on default. Its effective value goes out in parallel to the monitoring logic.

A control register holds a global override enable. While override is on, a write replaces a register's default with the written byte. Turning override off does not make every register fall back at once. Each register that holds a written value keeps it until that register is written again with override off. That write discards the byte and brings back the default. The bank also shows a read-only status byte supplied by the monitoring logic, and it decodes one wake-mode code from the effective configuration.

The bus decoder is a three-state machine. ST_IDLE ignores bytes. A start moves it from any state to ST_WAIT_PTR. In ST_WAIT_PTR a byte loads the pointer and moves it to ST_WAIT_DATA. In ST_WAIT_DATA a byte writes the selected register and returns it to ST_IDLE. If a start and a byte arrive in the same cycle, the start wins and the byte is dropped.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, rd_valid and rd_data are 0, ovr_en is 0, wake_edge_mode is 0, the pointer is 0 and every configuration register shows its default.
- R2: The first byte after bus_start loads the pointer with bits 6:0 of the byte; bit 7 is discarded.
- R3: One cycle after bus_rd, rd_valid pulses for one cycle. rd_data then carries bits 6:0 of the register the pointer selects, and bit 7 is 0. Repeated reads without a new pointer byte read the same address.
- R4: Address 0x16 is the control register, writable at any time; ovr_en equals its bit 3.
- R5: With ovr_en at 1, writing a configuration register (addresses 0x01 to NUM_CFG) makes its effective value equal to the written byte from the next cycle on.
- R6: Clearing ovr_en leaves every configuration register's effective value unchanged.
- R7: With ovr_en at 0, writing a configuration register returns it to its default, whatever byte was written.
- R8: A configuration register never written under override shows its default. Its default is ((address - 1) * 37) mod 128, so address 0x01 defaults to 0x00.
- R9: Address 0x19 reads status_in bits 6:0, and writes to it are ignored. Writes to unimplemented addresses are ignored, and reads from them return 0x00.
- R10: wake_edge_mode is 1 exactly when bits 3:0 of register 0x04's effective value are 1001.
- R11: A transaction writes only one data byte; further bytes before the next bus_start change neither the registers nor the pointer.
- R12: Bytes that arrive with no pending bus_start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start of a write transaction |
| bus_wr | input | 1 | A write byte is present on bus_wdata |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read request at the current pointer |
| status_in | input | 8 | Read-only status byte from the monitoring logic |
| rd_data | output | 8 | Read byte, bit 7 zero |
| rd_valid | output | 1 | rd_data valid, one-cycle pulse |
| cfg_flat | output | NUM_CFG*8 | Effective values, register a in bits (a-1)*8 +: 8 |
| ovr_en | output | 1 | Override enable in effect |
| wake_edge_mode | output | 1 | Rising-edge wake code selected in register 0x04 |

## Verification
A wrong per-register override flag shows on cfg_flat in the cycle after the write that set it. It also shows on every later read of that address, so a missed revert appears as a written byte surviving a write made with override off. A pointer or decoder state error shows as wrong rd_data one cycle after the next read request. The bench therefore reads back after every pointer change and after stray bytes. It also compares all of cfg_flat against a model after each write.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_PTR  = 2'd1,
        ST_WAIT_DATA = 2'd2
    } bus_state_e;

    localparam int          PTR_W     = 7;
    localparam logic [6:0]  CTRL_ADDR = 7'h16;
    localparam logic [6:0]  STAT_ADDR = 7'h19;
    localparam int          WAKE_IDX  = 4;
    localparam int          OVR_BIT   = 3;
    localparam logic [3:0]  WAKE_CODE = 4'b1001;

    // Power-on default of the configuration register at address idx
    function automatic logic [7:0] cfg_default(input int idx);
        return 8'(((idx - 1) * 37) % 128);
    endfunction

endpackage

// File: rtl/cfg_regbank_bus_fsm.sv
module cfg_regbank_bus_fsm
    import cfg_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data
);

    bus_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             byte_in;

    assign byte_in = bus_wr && !bus_start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = ST_WAIT_PTR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_PTR:  if (bus_wr) state_d = ST_WAIT_DATA;
                ST_WAIT_DATA: if (bus_wr) state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (state_q == ST_WAIT_PTR && byte_in) begin
            ptr_q <= bus_wdata[PTR_W-1:0];
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_data = bus_wdata;
        unique case (state_q)
            ST_IDLE:      wr_en = 1'b0;
            ST_WAIT_PTR:  wr_en = 1'b0;
            ST_WAIT_DATA: wr_en = byte_in;
            default:      wr_en = 1'b0;
        endcase
    end

    assign ptr = ptr_q;

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_PTR && byte_in) |=> (ptr_q == $past(bus_wdata[PTR_W-1:0])));

    // R11
    one_data_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DATA && byte_in) |=> (state_q == ST_IDLE));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bus_start) |=> ($stable(ptr_q) && !wr_en));

endmodule

// File: rtl/cfg_regbank_cell.sv
module cfg_regbank_cell #(
    parameter logic [7:0] DEF = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic       ovr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] eff
);

    logic       ovr_q;
    logic [7:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            val_q <= '0;
        end else if (wr_hit) begin
            if (ovr_en) begin
                ovr_q <= 1'b1;
                val_q <= wr_data;
            end else begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign eff = ovr_q ? val_q : DEF;

    // R5
    ovr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ovr_en) |=> (eff == $past(wr_data)));

    // R7
    revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ovr_en) |=> (eff == DEF));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(eff));

endmodule

// File: rtl/cfg_regbank_readmux.sv
module cfg_regbank_readmux
    import cfg_regbank_pkg::*;
#(
    parameter int NUM_CFG = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [NUM_CFG*8-1:0] cfg_flat,
    input  logic [7:0]         ctrl_val,
    input  logic [7:0]         status_in,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    logic [7:0] sel;
    logic [7:0] rd_data_q;
    logic       rd_valid_q;

    always_comb begin
        sel = 8'h00;
        for (int i = 1; i <= NUM_CFG; i++) begin
            if (ptr == PTR_W'(i)) sel = cfg_flat[(i-1)*8 +: 8];
        end
        if (ptr == CTRL_ADDR) sel = ctrl_val;
        if (ptr == STAT_ADDR) sel = status_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req) rd_data_q <= sel & 8'h7F;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R3
    rd_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_data[7]);

    // R9
    rd_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ptr > STAT_ADDR) |=> (rd_data == 8'h00));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int NUM_CFG = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_start,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_rd,
    input  logic [7:0]           status_in,
    output logic [7:0]           rd_data,
    output logic                 rd_valid,
    output logic [NUM_CFG*8-1:0] cfg_flat,
    output logic                 ovr_en,
    output logic                 wake_edge_mode
);

    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       ctrl_q;

    cfg_regbank_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    // control register, never subject to override
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ctrl_q <= 8'h00;
        else if (wr_en && ptr == CTRL_ADDR)     ctrl_q <= wr_data;
    end

    assign ovr_en = ctrl_q[OVR_BIT];

    for (genvar g = 1; g <= NUM_CFG; g++) begin : g_cell
        logic hit;
        assign hit = wr_en && (ptr == PTR_W'(g));
        cfg_regbank_cell #(.DEF(cfg_default(g))) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .ovr_en  (ovr_en),
            .wr_data (wr_data),
            .eff     (cfg_flat[(g-1)*8 +: 8])
        );
    end

    assign wake_edge_mode = (cfg_flat[(WAKE_IDX-1)*8 +: 4] == WAKE_CODE);

    cfg_regbank_readmux #(.NUM_CFG(NUM_CFG)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (bus_rd),
        .ptr       (ptr),
        .cfg_flat  (cfg_flat),
        .ctrl_val  (ctrl_q),
        .status_in (status_in),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // R4
    ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == CTRL_ADDR) |=> (ovr_en == $past(wr_data[OVR_BIT])));

    // R9
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr >= CTRL_ADDR && ptr != CTRL_ADDR) |=> ($stable(cfg_flat) && $stable(ovr_en)));

endmodule

// File: tb/cfg_regbank_tb_top.sv
`timescale 1ns/1ps
module cfg_regbank_tb_top;

    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_start = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = 8'h00;
    logic [7:0]   status_in = 8'h00;
    logic [7:0]   rd_data;
    logic         rd_valid;
    logic [N*8-1:0] cfg_flat;
    logic         ovr_en, wake_edge_mode;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [7:0] m_val [1:N];
    logic       m_ovr [1:N];
    logic [7:0] m_ctrl = 8'h00;
    logic [6:0] m_ptr  = 7'h00;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    cfg_regbank #(.NUM_CFG(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .status_in(status_in),
        .rd_data(rd_data), .rd_valid(rd_valid), .cfg_flat(cfg_flat),
        .ovr_en(ovr_en), .wake_edge_mode(wake_edge_mode)
    );

    function automatic logic [7:0] def_of(int a);
        return 8'(((a - 1) * 37) % 128);
    endfunction

    function automatic logic [7:0] m_eff(int a);
        return m_ovr[a] ? m_val[a] : def_of(a);
    endfunction

    function automatic logic [7:0] m_read(logic [6:0] p);
        if (p >= 7'd1 && p <= 7'(N)) return m_eff(int'(p)) & 8'h7F;
        if (p == 7'h16) return m_ctrl & 8'h7F;
        if (p == 7'h19) return status_in & 8'h7F;
        return 8'h00;
    endfunction

    task automatic model_write(logic [6:0] p, logic [7:0] d);
        if (p == 7'h16) m_ctrl = d;
        else if (p >= 7'd1 && p <= 7'(N)) begin
            if (m_ctrl[3]) begin m_val[int'(p)] = d; m_ovr[int'(p)] = 1'b1; end
            else m_ovr[int'(p)] = 1'b0;
        end
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_cfg(string tag);
        for (int a = 1; a <= N; a++)
            check(tag, cfg_flat[(a-1)*8 +: 8], m_eff(a));
        check(tag, {7'd0, ovr_en}, {7'd0, m_ctrl[3]});
        check(tag, {7'd0, wake_edge_mode}, {7'd0, m_eff(4)[3:0] == 4'b1001});
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_ptr(logic [7:0] p);
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
        bus_wr = 1'b1; bus_wdata = p;
        @(negedge clk); bus_wr = 1'b0;
        m_ptr = p[6:0];
    endtask

    task automatic wr_txn(logic [7:0] p, logic [7:0] d);
        set_ptr(p);
        send_byte(d);
        model_write(p[6:0], d);
    endtask

    // driver: pushes expected read result, then requests the read
    task automatic do_read(string tag);
        exp_q.push_back(m_read(m_ptr));
        tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops and compares as read results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3: unexpected read actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 1; a <= N; a++) begin m_val[a] = 8'h00; m_ovr[a] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R8 defaults
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        check_cfg("R1 R8 reset cfg");
        do_read("R1 pointer zero reads 0x00");

        // R2 pointer load, bit 7 dropped
        set_ptr(8'h01);
        do_read("R2 read reg 0x01 default");
        set_ptr(8'h85);
        do_read("R2 pointer bit7 discarded");
        // R3 repeated read without new pointer
        do_read("R3 reread same pointer");

        // R8 write without override has no effect
        wr_txn(8'h03, 8'h5C);
        check_cfg("R8 write while override off");

        // R4 override enable
        wr_txn(8'h16, 8'h08);
        check_cfg("R4 override enabled");
        do_read("R4 read control");

        // R5 override writes, R3 bit7 masked
        wr_txn(8'h03, 8'hA5);
        check_cfg("R5 reg3 overridden");
        do_read("R3 R5 read masked bit7");
        wr_txn(8'h04, 8'h09);
        check_cfg("R10 wake code selected");
        wr_txn(8'h02, 8'h11);

        // R6 clearing override keeps values
        wr_txn(8'h16, 8'h00);
        check_cfg("R6 override cleared, values kept");

        // R7 per-register revert
        wr_txn(8'h03, 8'h77);
        check_cfg("R7 reg3 reverted, reg2 kept");
        do_read("R7 read reverted reg3");
        wr_txn(8'h04, 8'h09);
        check_cfg("R7 R10 reg4 reverted, wake cleared");

        // R9 status read-only, unimplemented addresses
        status_in = 8'hDA;
        wr_txn(8'h19, 8'hFF);
        check_cfg("R9 write to status ignored");
        do_read("R9 status read");
        wr_txn(8'h30, 8'h42);
        check_cfg("R9 write to unimplemented ignored");
        do_read("R9 unimplemented reads 0x00");

        // R11 extra bytes in a transaction ignored
        wr_txn(8'h16, 8'h08);
        wr_txn(8'h02, 8'h33);
        send_byte(8'h05);
        send_byte(8'h66);
        check_cfg("R11 extra bytes ignored");
        do_read("R11 pointer unchanged after extra bytes");

        // R12 bytes with no start ignored
        send_byte(8'h07);
        send_byte(8'h01);
        check_cfg("R12 stray bytes ignored");
        do_read("R12 pointer unchanged after stray bytes");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R3: missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule